// File: doc/BRIEF.md
# PCI Slot Interrupt Router with Mapping Autodetect

This block gathers the four level-sensitive interrupt pins of every PCI slot on a backplane and folds them onto four host interrupt lines. Each host line is high while at least one slot pin routed to it is high. The routing depends on a mapping mode. In the legacy mode, pin n of every slot drives host line n, whatever the slot. In the other two modes, a slot-dependent rotation is used. The rotation constant depends on a board-variant strap, because one board's wiring shifts every pin by one position.

The mode comes out of reset in a value chosen by a strap-like input. While the mode is still undecided, the block watches configuration writes to the interrupt-line byte of any function. The value host software writes there shows whether that software expects the legacy mapping. The first write that tells the two cases apart decides the mode, and the mode then stays fixed until the next reset. Software that expects the correct mapping can disable the detector by writing any value that cannot be mistaken for a legacy one. Detection is disabled entirely on the alternate board variant.

Top module: `pci_irq_router`

## Requirements
- R1: On the clock edge where synchronous active-low `rst_n` is low, `mode` loads `rst_mode`, with the encodings 0 = undecided, 1 = legacy, 2 = correct; the code 3 loads undecided.
- R2: A qualifying configuration write changes `mode` at the next rising clock edge, not in the cycle of the write.
- R3: Once `mode` is legacy or correct, it keeps that value until reset, whatever writes follow.
- R4: A write qualifies only when all of these hold: `cfg_wr_valid` is 1, `alt_variant` is 0, `cfg_wr_addr[7:0]` is 0x3C, and `mode` is undecided. Any other write leaves `mode` unchanged.
- R5: The slot of a write is `cfg_wr_addr[15:11]`, and m is that slot mod 4. If the written byte is 27 and m is 2, `mode` stays undecided. If the byte is 27 and m is any other value, `mode` becomes legacy.
- R6: A written byte equal to m+27 or m+91 sets `mode` to legacy.
- R7: Any other written byte sets `mode` to correct.
- R8: In legacy mode, pin p of every slot drives `irq_out[p]`. Pin bits 0..3 are INTA..INTD, and the pins of source i are `slot_pins[4*i+3:4*i]`.
- R9: In undecided or correct mode with `alt_variant` = 0, pin p of source i drives `irq_out[(FIRST_SLOT+i+p+2) mod 4]`.
- R10: In undecided or correct mode with `alt_variant` = 1, pin p of source i drives `irq_out[(FIRST_SLOT+i+p+3) mod 4]`.
- R11: Each `irq_out` bit is the OR of every pin routed to it. It follows pin, strap and mode changes combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_mode | input | 2 | Mode loaded during reset |
| alt_variant | input | 1 | Board variant strap; 1 selects the +3 rotation and disables detection |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 16 | Configuration write address: slot in [15:11], register offset in [7:0] |
| cfg_wr_data | input | 8 | Byte written to the addressed register |
| slot_pins | input | 4*NSLOT | Interrupt pin levels, 4 per slot |
| irq_out | output | 4 | Host interrupt lines |
| mode | output | 2 | Current mapping mode |

## Verification
The hardest situations to reach are the ones the detector must not react to. These are a 27 written in a slot whose residue is 2, a write with the right value at a neighbouring offset, and a legacy-looking value seen on the alternate variant or after the mode has locked. Each of them looks almost like a trigger. The bench resets several times and, in each run, first applies such near-miss writes and then the decisive one. It reaches every residue for both the 27-based and the 91-based legacy values. In every mode, it compares the host lines each clock against a behavioural model while random pin patterns are applied.

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int NSLOT      = 3,
  parameter int FIRST_SLOT = 29,
  parameter logic [7:0] LINE_OFS = 8'h3C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rst_mode,
  input  logic               alt_variant,
  input  logic               cfg_wr_valid,
  input  logic [15:0]        cfg_wr_addr,
  input  logic [7:0]         cfg_wr_data,
  input  logic [4*NSLOT-1:0] slot_pins,
  output logic [3:0]         irq_out,
  output logic [1:0]         mode
);
  localparam logic [1:0] M_UNDEC  = 2'd0;
  localparam logic [1:0] M_LEGACY = 2'd1;
  localparam logic [1:0] M_GOOD   = 2'd2;

  logic [1:0] slot_m;
  logic [7:0] m27, m91;
  logic       hit;
  logic [1:0] verdict;
  logic       unused_fn;

  assign unused_fn = ^cfg_wr_addr[10:8];
  assign slot_m    = cfg_wr_addr[12:11];
  assign m27       = 8'd27 + {6'd0, slot_m};
  assign m91       = 8'd91 + {6'd0, slot_m};
  assign hit       = cfg_wr_valid && !alt_variant && (mode == M_UNDEC)
                     && (cfg_wr_addr[7:0] == LINE_OFS);

  always_comb begin
    if (cfg_wr_data == 8'd27)
      verdict = (slot_m == 2'd2) ? M_UNDEC : M_LEGACY;
    else if (cfg_wr_data == m27 || cfg_wr_data == m91)
      verdict = M_LEGACY;
    else
      verdict = M_GOOD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode <= (rst_mode == 2'd3) ? M_UNDEC : rst_mode;
    else if (hit)
      mode <= verdict;
  end

  always_comb begin
    logic [1:0] rot;
    logic [1:0] idx;
    rot = alt_variant ? 2'd3 : 2'd2;
    irq_out = '0;
    for (int i = 0; i < NSLOT; i++) begin
      for (int p = 0; p < 4; p++) begin
        if (mode == M_LEGACY)
          idx = 2'(p);
        else
          idx = 2'(FIRST_SLOT + i + p) + rot;
        irq_out[idx] = irq_out[idx] | slot_pins[4*i+p];
      end
    end
  end
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int NSLOT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         rst_mode,
  input logic               alt_variant,
  input logic               cfg_wr_valid,
  input logic [15:0]        cfg_wr_addr,
  input logic [4*NSLOT-1:0] slot_pins,
  input logic [3:0]         irq_out,
  input logic [1:0]         mode
);
  assert_reset_load_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> mode == (($past(rst_mode) == 2'd3) ? 2'd0 : $past(rst_mode)));

  assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> $stable(mode));

  assert_no_write_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_valid |=> $stable(mode));

  assert_alt_no_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alt_variant |=> $stable(mode));

  assert_wrong_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_addr[7:0] != 8'h3C) |=> $stable(mode));

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  assert_quiet_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pins == '0) |-> (irq_out == 4'd0));

  assert_lines_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(slot_pins));
endmodule

bind pci_irq_router pci_irq_router_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_mode(rst_mode), .alt_variant(alt_variant),
  .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr),
  .slot_pins(slot_pins), .irq_out(irq_out), .mode(mode)
);

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb;
  localparam int NSLOT = 3;
  localparam int FIRST = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rst_mode = 2'd0;
  logic alt_variant = 1'b0;
  logic cfg_wr_valid = 1'b0;
  logic [15:0] cfg_wr_addr = '0;
  logic [7:0] cfg_wr_data = '0;
  logic [4*NSLOT-1:0] slot_pins = '0;
  logic [3:0] irq_out;
  logic [1:0] mode;

  int vectors = 0;
  int miscompares = 0;
  int m_mode = 0;

  always #2.5 clk = ~clk;

  pci_irq_router #(.NSLOT(NSLOT), .FIRST_SLOT(FIRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_mode(rst_mode), .alt_variant(alt_variant),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .slot_pins(slot_pins),
    .irq_out(irq_out), .mode(mode)
  );

  // reference model of the mode register
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = (rst_mode == 2'd3) ? 0 : int'(rst_mode);
    end else if (m_mode == 0 && cfg_wr_valid && !alt_variant
                 && cfg_wr_addr[7:0] == 8'h3C) begin
      int s;
      int v;
      s = (int'(cfg_wr_addr) / 2048) % 4;
      v = int'(cfg_wr_data);
      if (v == 27) m_mode = (s == 2) ? 0 : 1;
      else if (v == s + 27 || v == s + 91) m_mode = 1;
      else m_mode = 2;
    end
  end

  function automatic logic [3:0] expect_lines();
    logic [3:0] r;
    r = '0;
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < NSLOT; s++) begin
        for (int p = 0; p < 4; p++) begin
          if (slot_pins[4*s+p]) begin
            if (m_mode == 1) begin
              if (p == o) r[o] = 1'b1;
            end else if ((FIRST + s + p + (alt_variant ? 3 : 2)) % 4 == o) begin
              r[o] = 1'b1;
            end
          end
        end
      end
    end
    return r;
  endfunction

  task automatic cyc(input string tag);
    @(negedge clk);
    vectors++;
    if (int'(mode) != m_mode) begin
      miscompares++;
      $display("FAIL %s mode: got %0d expected %0d", tag, mode, m_mode);
    end
    if (irq_out !== expect_lines()) begin
      miscompares++;
      $display("FAIL %s irq_out: got %b expected %b", tag, irq_out, expect_lines());
    end
  endtask

  task automatic do_reset(input logic [1:0] rm);
    rst_mode = rm;
    rst_n = 1'b0;
    alt_variant = 1'b0;
    cyc("R1");
    cyc("R1");
    rst_n = 1'b1;
    cyc("R1");
  endtask

  task automatic cfg_write(input int slot, input logic [7:0] ofs,
                           input logic [7:0] val, input string tag);
    cfg_wr_valid = 1'b1;
    cfg_wr_addr = {5'(slot), 3'd0, ofs};
    cfg_wr_data = val;
    cyc(tag);
    cfg_wr_valid = 1'b0;
    cyc(tag);
  endtask

  task automatic pin_sweep(input string tag);
    for (int b = 0; b < 4*NSLOT; b++) begin
      slot_pins = '0;
      slot_pins[b] = 1'b1;
      cyc(tag);
    end
    for (int k = 0; k < 40; k++) begin
      slot_pins = (4*NSLOT)'($urandom);
      cyc(tag);
    end
    slot_pins = '1;
    cyc(tag);
    slot_pins = '0;
    cyc(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: every reset code
    do_reset(2'd1); pin_sweep("R8_reset_legacy");
    do_reset(2'd2); pin_sweep("R9_reset_correct");
    do_reset(2'd3); cyc("R1_code3");
    do_reset(2'd0);
    pin_sweep("R9_R11_undecided");
    alt_variant = 1'b1;
    pin_sweep("R10_alt_undecided");
    // R4: alternate variant disables detection
    cfg_write(29, 8'h3C, 8'd27, "R4_alt");
    alt_variant = 1'b0;
    // R4: neighbouring offset ignored
    cfg_write(29, 8'h3D, 8'd27, "R4_offset");
    cfg_write(29, 8'h3C, 8'd27, "R4_novalid_skip");
    // that write locked legacy from slot 29 (m=1): R5
    cyc("R5_slot1");
    pin_sweep("R8_legacy");
    cfg_write(30, 8'h3C, 8'd50, "R3_legacy_lock");
    cyc("R3");

    // R5: 27 in residue-2 slot keeps undecided
    do_reset(2'd0);
    cfg_write(30, 8'h3C, 8'd27, "R5_slot2_stays");
    cfg_write(30, 8'h3C, 8'd93, "R6_slot2_91");
    pin_sweep("R8_after_R6");

    for (int m = 0; m < 4; m++) begin
      do_reset(2'd0);
      cfg_write(28 + m, 8'h3C, 8'(27 + m), "R6_plus27");
      do_reset(2'd0);
      cfg_write(28 + m, 8'h3C, 8'(91 + m), "R6_plus91");
      do_reset(2'd0);
      cfg_write(28 + m, 8'h3C, 8'(28 + ((m + 1) % 4)), "R7_other");
    end

    // R7 then lock, plus alternate routing in correct mode
    do_reset(2'd0);
    cfg_wr_valid = 1'b1;
    cfg_wr_addr = {5'd31, 3'd0, 8'h3C};
    cfg_wr_data = 8'd99;
    cyc("R2_same_cycle");
    cfg_wr_valid = 1'b0;
    cyc("R2_next_edge");
    cfg_write(28, 8'h3C, 8'd27, "R3_correct_lock");
    pin_sweep("R9_correct");
    alt_variant = 1'b1;
    pin_sweep("R10_correct_alt");
    alt_variant = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule